// File: doc/BRIEF.md
# Descriptor-Driven SHA-256 Digest Checker

This block walks a list of hash jobs stored in word-addressed memory and steers an external SHA-256 compression unit through each one. Every job starts with a header word that gives the number of 64-byte blocks and a flag that says whether each block hashes from a fresh state. Three words follow the header: an index that is passed to the round unit as a tag, the byte address of the message, and the byte address of the expected 8-word digest. For each block the engine gives the round unit its starting state, streams sixteen message words read from memory, collects the compressed state, and folds it into the chaining state. After the final block of a job it reads the stored digest back and compares it word by word. A mismatch sets a sticky flag. A header with a zero block count ends the list and raises a one-cycle done pulse.

The state machine has these states. Descriptor fetch: `ST_HDR_RD`→`ST_HDR_USE`, then `ST_IDX_RD`→`ST_IDX_USE`, then `ST_SRC_RD`→`ST_SRC_USE`, then `ST_DIG_RD`→`ST_DIG_USE`. Block setup: `ST_BLK_INIT`→`ST_RND_GO`. Message loop: `ST_MSG_RD`⇄`ST_MSG_USE`, repeated 16 times, then `ST_RND_WAIT`. Folding: `ST_FOLD`, 4 cycles. Digest compare: `ST_CMP_RD`⇄`ST_CMP_USE`, repeated 8 times. Block end: `ST_BLK_END`. Termination: `ST_DONE`→`ST_HALT`.

The transitions are as follows. `ST_HDR_USE` goes to `ST_DONE` on a zero count. `ST_FOLD` goes to the compare states only on a job's last block. `ST_BLK_END` goes back to `ST_HDR_RD` after the last block, and otherwise to `ST_BLK_INIT` with no descriptor fetches. Each `_RD` state holds its request until the memory accepts it.

Top module: `sha_digest_verifier`

## Requirements
- R1: After reset all output strobes are low. The count, flags and pointers are cleared. The first read accepted is at word address `BASE_ADDR`.
- R2: In a header word, bits [15:0] give the block count and bits [31:16] give the fresh-state flag, which is set when that field is nonzero. A count of zero ends the list. The engine raises `done` for exactly one cycle and then issues no further reads.
- R3: The three words after a header are read at the next three addresses. The first is presented on `rnd_tag`. The second is a byte address whose word address (byte address / 4) is the message pointer. The third is a byte address whose word address plus 7 is the digest pointer.
- R4: Each block reads 16 consecutive words from the message pointer, which advances by one word per read. The words go to the round unit in order on `rnd_msg`, one per `rnd_msg_valid` cycle, and each word is delivered in the cycle after its read is accepted.
- R5: Between the blocks of one job, no descriptor words are read. The next block continues at the following message word, and the tag and digest pointer are kept.
- R6: A block starts from the fixed initial state (SHA-256 IV, word k at bits [32k+31:32k] of `rnd_init`) when it is a job's first block or the job's fresh-state flag is set.
- R7: Otherwise the block starts from the chaining state of the previous block. That state is the previous block's starting state plus the round result, word by word modulo 2^32, folded as pairs (k, k+4) for k = 0..3 over four cycles.
- R8: After a job's last block, 8 digest words are read from the digest pointer downward, and the word read at step j is compared with chaining word 7−j. Non-final blocks read no digest words.
- R9: Any compare that differs sets `mismatch`, which stays set until reset.
- R10: While `mem_rdy` is low, `mem_req` stays high with a stable `mem_addr`. Read data arrives one cycle after acceptance.
- R11: `rnd_start` is a one-cycle pulse, once per block, never in the same cycle as `rnd_msg_valid`, and it comes before that block's message words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rdy | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after acceptance |
| rnd_start | output | 1 | Begin a block on the round unit |
| rnd_init | output | 256 | Starting state for the block |
| rnd_tag | output | 32 | Job index word |
| rnd_msg_valid | output | 1 | Message word strobe |
| rnd_msg | output | 32 | Message word |
| rnd_done | input | 1 | Round unit result valid (one cycle) |
| rnd_result | input | 256 | Compressed state from the round unit |
| done | output | 1 | One-cycle pulse at the end of the list |
| mismatch | output | 1 | Sticky digest-compare failure |

## Verification
The bench runs three lists. The first mixes a chained two-block job, a fresh-state two-block job and a single-block job under an irregular `mem_rdy` pattern. The second is the same list with one stored digest word corrupted. The third is an empty list. A design that refetched descriptors between blocks, or restarted the message pointer, would show up as an unexpected read address. A design that chained state in fresh-state mode, or folded the wrong lane pair, would present a wrong `rnd_init` on the following block. A design that walked the digest upward, or compared against the wrong chaining word, would raise `mismatch` on the clean list. A design that let go of its address during a stall, or kept reading after the end marker, would fail the stall and read-list checks.

// File: rtl/sdv_pkg.sv
package sdv_pkg;

    localparam int WORD_W     = 32;
    localparam int ST_WORDS   = 8;
    localparam int HALF_WORDS = ST_WORDS / 2;
    localparam int ST_W       = WORD_W * ST_WORDS;
    localparam int CNT_W      = 16;

    // word k lives at bits [32k+31:32k]
    localparam logic [ST_W-1:0] SHA256_IV = {
        32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
        32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667
    };

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [4:0] {
        ST_HDR_RD,
        ST_HDR_USE,
        ST_IDX_RD,
        ST_IDX_USE,
        ST_SRC_RD,
        ST_SRC_USE,
        ST_DIG_RD,
        ST_DIG_USE,
        ST_BLK_INIT,
        ST_RND_GO,
        ST_MSG_RD,
        ST_MSG_USE,
        ST_RND_WAIT,
        ST_FOLD,
        ST_CMP_RD,
        ST_CMP_USE,
        ST_BLK_END,
        ST_DONE,
        ST_HALT
    } sdv_state_e;

    typedef enum logic [1:0] {
        ASEL_DESC,
        ASEL_SRC,
        ASEL_DIG
    } addr_sel_e;

    typedef struct packed {
        logic ld_hdr;
        logic ld_idx;
        logic ld_src;
        logic ld_dig;
        logic src_inc;
        logic dig_dec;
        logic blk_adv;
    } ptr_ctl_t;

endpackage

// File: rtl/sdv_fsm.sv
module sdv_fsm
    import sdv_pkg::*;
#(
    parameter int BLK_WORDS = 16,
    parameter int STEP_W    = 5,
    parameter int IDX_W     = 3,
    parameter int LANE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_rdy,
    input  logic              hdr_zero,
    input  logic              last_blk,
    input  logic              rnd_done,
    output logic              mem_req,
    output addr_sel_e         addr_sel,
    output ptr_ctl_t          ctl,
    output logic              rnd_start,
    output logic              msg_valid,
    output logic              load_chain,
    output logic              cap_res,
    output logic              fold_en,
    output logic              cmp_en,
    output logic              done,
    output logic [LANE_W-1:0] lane,
    output logic [IDX_W-1:0]  word_sel
);

    localparam logic [STEP_W-1:0] MSG_LAST  = STEP_W'(BLK_WORDS - 1);
    localparam logic [STEP_W-1:0] FOLD_LAST = STEP_W'(HALF_WORDS - 1);
    localparam logic [STEP_W-1:0] CMP_LAST  = STEP_W'(ST_WORDS - 1);

    sdv_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HDR_RD;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_HDR_RD:   if (mem_rdy) state_d = ST_HDR_USE;
            ST_HDR_USE:  state_d = hdr_zero ? ST_DONE : ST_IDX_RD;
            ST_IDX_RD:   if (mem_rdy) state_d = ST_IDX_USE;
            ST_IDX_USE:  state_d = ST_SRC_RD;
            ST_SRC_RD:   if (mem_rdy) state_d = ST_SRC_USE;
            ST_SRC_USE:  state_d = ST_DIG_RD;
            ST_DIG_RD:   if (mem_rdy) state_d = ST_DIG_USE;
            ST_DIG_USE:  state_d = ST_BLK_INIT;
            ST_BLK_INIT: state_d = ST_RND_GO;
            ST_RND_GO: begin
                step_d  = '0;
                state_d = ST_MSG_RD;
            end
            ST_MSG_RD:   if (mem_rdy) state_d = ST_MSG_USE;
            ST_MSG_USE: begin
                step_d  = step_q + 1'b1;
                state_d = (step_q == MSG_LAST) ? ST_RND_WAIT : ST_MSG_RD;
            end
            ST_RND_WAIT: begin
                step_d = '0;
                if (rnd_done) state_d = ST_FOLD;
            end
            ST_FOLD: begin
                step_d = step_q + 1'b1;
                if (step_q == FOLD_LAST) begin
                    step_d  = '0;
                    state_d = last_blk ? ST_CMP_RD : ST_BLK_END;
                end
            end
            ST_CMP_RD:   if (mem_rdy) state_d = ST_CMP_USE;
            ST_CMP_USE: begin
                step_d  = step_q + 1'b1;
                state_d = (step_q == CMP_LAST) ? ST_BLK_END : ST_CMP_RD;
            end
            ST_BLK_END:  state_d = last_blk ? ST_HDR_RD : ST_BLK_INIT;
            ST_DONE:     state_d = ST_HALT;
            ST_HALT:     state_d = ST_HALT;
            default:     state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        addr_sel   = ASEL_DESC;
        ctl        = '0;
        rnd_start  = 1'b0;
        msg_valid  = 1'b0;
        load_chain = 1'b0;
        cap_res    = 1'b0;
        fold_en    = 1'b0;
        cmp_en     = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_HDR_RD, ST_IDX_RD, ST_SRC_RD, ST_DIG_RD: mem_req = 1'b1;
            ST_HDR_USE:  ctl.ld_hdr = 1'b1;
            ST_IDX_USE:  ctl.ld_idx = 1'b1;
            ST_SRC_USE:  ctl.ld_src = 1'b1;
            ST_DIG_USE:  ctl.ld_dig = 1'b1;
            ST_BLK_INIT: load_chain = 1'b1;
            ST_RND_GO:   rnd_start = 1'b1;
            ST_MSG_RD: begin
                mem_req  = 1'b1;
                addr_sel = ASEL_SRC;
            end
            ST_MSG_USE: begin
                msg_valid   = 1'b1;
                ctl.src_inc = 1'b1;
            end
            ST_RND_WAIT: cap_res = rnd_done;
            ST_FOLD:     fold_en = 1'b1;
            ST_CMP_RD: begin
                mem_req  = 1'b1;
                addr_sel = ASEL_DIG;
            end
            ST_CMP_USE: begin
                cmp_en      = 1'b1;
                ctl.dig_dec = 1'b1;
            end
            ST_BLK_END:  ctl.blk_adv = !last_blk;
            ST_DONE:     done = 1'b1;
            default: ;
        endcase
    end

    assign lane     = step_q[LANE_W-1:0];
    assign word_sel = IDX_W'(ST_WORDS - 1) - step_q[IDX_W-1:0];

endmodule

// File: rtl/sdv_ptrs.sv
module sdv_ptrs
    import sdv_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ptr_ctl_t          ctl,
    input  word_t             rdata,
    output logic [ADDR_W-1:0] desc_ptr,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dig_ptr,
    output word_t             job_idx,
    output logic              last_blk,
    output logic              keep_chain
);

    localparam logic [ADDR_W-1:0] DIG_TAIL = ADDR_W'(ST_WORDS - 1);

    logic [CNT_W-1:0] count_q;
    logic             fresh_q;
    logic             cont_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ptr <= BASE_ADDR;
            src_ptr  <= '0;
            dig_ptr  <= '0;
            job_idx  <= '0;
            count_q  <= '0;
            fresh_q  <= 1'b0;
            cont_q   <= 1'b0;
        end else begin
            if (ctl.ld_hdr | ctl.ld_idx | ctl.ld_src | ctl.ld_dig)
                desc_ptr <= desc_ptr + 1'b1;
            if (ctl.ld_hdr) begin
                count_q <= rdata[CNT_W-1:0];
                fresh_q <= |rdata[WORD_W-1:CNT_W];
                cont_q  <= 1'b0;
            end
            if (ctl.ld_idx) job_idx <= rdata;
            if (ctl.ld_src)       src_ptr <= rdata[ADDR_W+1:2];
            else if (ctl.src_inc) src_ptr <= src_ptr + 1'b1;
            if (ctl.ld_dig)       dig_ptr <= rdata[ADDR_W+1:2] + DIG_TAIL;
            else if (ctl.dig_dec) dig_ptr <= dig_ptr - 1'b1;
            if (ctl.blk_adv) begin
                count_q <= count_q - 1'b1;
                cont_q  <= 1'b1;
            end
        end
    end

    assign last_blk   = (count_q == CNT_W'(1));
    assign keep_chain = cont_q & ~fresh_q;

endmodule

// File: rtl/sdv_chain.sv
module sdv_chain
    import sdv_pkg::*;
#(
    parameter logic [ST_W-1:0] INIT_STATE = SHA256_IV,
    parameter int              IDX_W      = 3,
    parameter int              LANE_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_iv,
    input  logic              cap_res,
    input  logic [ST_W-1:0]   res,
    input  logic              fold_en,
    input  logic [LANE_W-1:0] lane,
    input  logic [IDX_W-1:0]  word_sel,
    output logic [ST_W-1:0]   chain_flat,
    output word_t             sel_word
);

    for (genvar g = 0; g < ST_WORDS; g++) begin : g_word
        localparam logic [LANE_W-1:0] MY_LANE = LANE_W'(g % HALF_WORDS);
        word_t chain_q;
        word_t work_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
                work_q  <= '0;
            end else begin
                if (cap_res)
                    work_q <= res[g*WORD_W +: WORD_W];
                if (load_iv)
                    chain_q <= INIT_STATE[g*WORD_W +: WORD_W];
                else if (fold_en && lane == MY_LANE)
                    chain_q <= chain_q + work_q;
            end
        end

        assign chain_flat[g*WORD_W +: WORD_W] = chain_q;
    end

    assign sel_word = chain_flat[word_sel*WORD_W +: WORD_W];

endmodule

// File: rtl/sha_digest_verifier.sv
module sha_digest_verifier
    import sdv_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = ADDR_W'(16),
    parameter int                BLK_WORDS  = 16,
    parameter logic [ST_W-1:0]   INIT_STATE = SHA256_IV
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rdy,
    input  logic [31:0]       mem_rdata,
    output logic              rnd_start,
    output logic [255:0]      rnd_init,
    output logic [31:0]       rnd_tag,
    output logic              rnd_msg_valid,
    output logic [31:0]       rnd_msg,
    input  logic              rnd_done,
    input  logic [255:0]      rnd_result,
    output logic              done,
    output logic              mismatch
);

    localparam int STEP_W = $clog2(BLK_WORDS) + 1;
    localparam int IDX_W  = $clog2(ST_WORDS);
    localparam int LANE_W = $clog2(HALF_WORDS);

    addr_sel_e         addr_sel;
    ptr_ctl_t          ctl;
    logic              load_chain, cap_res, fold_en, cmp_en;
    logic              last_blk, keep_chain;
    logic [LANE_W-1:0] lane;
    logic [IDX_W-1:0]  word_sel;
    logic [ADDR_W-1:0] desc_ptr, src_ptr, dig_ptr;
    word_t             sel_word;
    logic              hdr_zero;

    assign hdr_zero = (mem_rdata[CNT_W-1:0] == '0);

    sdv_fsm #(
        .BLK_WORDS (BLK_WORDS),
        .STEP_W    (STEP_W),
        .IDX_W     (IDX_W),
        .LANE_W    (LANE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_rdy    (mem_rdy),
        .hdr_zero   (hdr_zero),
        .last_blk   (last_blk),
        .rnd_done   (rnd_done),
        .mem_req    (mem_req),
        .addr_sel   (addr_sel),
        .ctl        (ctl),
        .rnd_start  (rnd_start),
        .msg_valid  (rnd_msg_valid),
        .load_chain (load_chain),
        .cap_res    (cap_res),
        .fold_en    (fold_en),
        .cmp_en     (cmp_en),
        .done       (done),
        .lane       (lane),
        .word_sel   (word_sel)
    );

    sdv_ptrs #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .rdata      (mem_rdata),
        .desc_ptr   (desc_ptr),
        .src_ptr    (src_ptr),
        .dig_ptr    (dig_ptr),
        .job_idx    (rnd_tag),
        .last_blk   (last_blk),
        .keep_chain (keep_chain)
    );

    sdv_chain #(
        .INIT_STATE (INIT_STATE),
        .IDX_W      (IDX_W),
        .LANE_W     (LANE_W)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_iv    (load_chain & ~keep_chain),
        .cap_res    (cap_res),
        .res        (rnd_result),
        .fold_en    (fold_en),
        .lane       (lane),
        .word_sel   (word_sel),
        .chain_flat (rnd_init),
        .sel_word   (sel_word)
    );

    always_comb begin
        unique case (addr_sel)
            ASEL_SRC: mem_addr = src_ptr;
            ASEL_DIG: mem_addr = dig_ptr;
            default:  mem_addr = desc_ptr;
        endcase
    end

    assign rnd_msg = mem_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mismatch <= 1'b0;
        else if (cmp_en && (mem_rdata != sel_word))
            mismatch <= 1'b1;
    end

endmodule

// File: rtl/sdv_checker.sv
module sdv_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rdy,
    input logic              rnd_start,
    input logic              rnd_msg_valid,
    input logic              done,
    input logic              mismatch
);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_quiet_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !mem_req);

    assert_msg_from_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_msg_valid |-> $past(mem_req && mem_rdy));

    assert_mismatch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> mismatch);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));

    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_start |=> !rnd_start);

    assert_start_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_start |-> !rnd_msg_valid);

endmodule

bind sha_digest_verifier sdv_checker #(.ADDR_W(ADDR_W)) u_sdv_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rdy       (mem_rdy),
    .rnd_start     (rnd_start),
    .rnd_msg_valid (rnd_msg_valid),
    .done          (done),
    .mismatch      (mismatch)
);

// File: tb/test_sha_digest_verifier.sv
module test_sha_digest_verifier;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int BASE       = 16;
    localparam int WDOG       = 20000;
    localparam logic [255:0] IV = {
        32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
        32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rdy = 1'b1;
    logic [31:0]   mem_rdata = '0;
    logic          rnd_start;
    logic [255:0]  rnd_init;
    logic [31:0]   rnd_tag;
    logic          rnd_msg_valid;
    logic [31:0]   rnd_msg;
    logic          rnd_done = 1'b0;
    logic [255:0]  rnd_result = '0;
    logic          done;
    logic          mismatch;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int done_cnt = 0;
    int start_cnt = 0;
    int exp_starts = 0;

    logic [31:0]  mem [0:1023];
    int           exp_addr[$];
    string        exp_atag[$];
    logic [255:0] exp_init[$];
    string        exp_itag[$];
    logic [31:0]  exp_idx[$];
    logic [31:0]  exp_msg[$];

    sha_digest_verifier #(.ADDR_W(AW), .BASE_ADDR(AW'(BASE))) i_sha_digest_verifier (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .rnd_start(rnd_start),
        .rnd_init(rnd_init), .rnd_tag(rnd_tag), .rnd_msg_valid(rnd_msg_valid),
        .rnd_msg(rnd_msg), .rnd_done(rnd_done), .rnd_result(rnd_result),
        .done(done), .mismatch(mismatch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // round unit stand-in: an arbitrary but fixed mixing of start state and words
    function automatic logic [255:0] mix(input logic [255:0] init, input logic [15:0][31:0] m);
        logic [255:0] o;
        for (int i = 0; i < 8; i++)
            o[32*i +: 32] = (init[32*i +: 32] ^ m[i]) + m[i+8] + 32'(i);
        return o;
    endfunction

    function automatic logic [255:0] fold(input logic [255:0] a, input logic [255:0] b);
        logic [255:0] o;
        for (int i = 0; i < 8; i++)
            o[32*i +: 32] = a[32*i +: 32] + b[32*i +: 32];
        return o;
    endfunction

    // memory: data one cycle after acceptance
    always @(posedge clk)
        if (mem_req && mem_rdy) mem_rdata <= mem[mem_addr[9:0]];

    initial begin
        forever begin
            @(posedge clk);
            #1;
            mem_rdy = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1 && (cyc % 7) != 0);
        end
    end

    logic [255:0]       rm_init;
    logic [15:0][31:0]  rm_msg;
    int                 rm_n = 0;
    int                 rm_wait = -1;
    always @(posedge clk) begin
        rnd_done <= 1'b0;
        if (!rst_n) begin
            rm_n = 0;
            rm_wait = -1;
        end else begin
            if (rnd_start) begin
                rm_init = rnd_init;
                rm_n = 0;
            end
            if (rnd_msg_valid) begin
                if (rm_n < 16) rm_msg[rm_n] = rnd_msg;
                rm_n++;
                if (rm_n == 16) rm_wait = 3;
            end else if (rm_wait > 0) begin
                rm_wait--;
            end else if (rm_wait == 0) begin
                rnd_result <= mix(rm_init, rm_msg);
                rnd_done <= 1'b1;
                rm_wait = -1;
            end
        end
    end

    // per-cycle comparison against the planned event lists
    bit            prev_stall = 0;
    logic [AW-1:0] prev_addr = '0;
    bit            prev_start = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(mem_req && mem_addr == prev_addr, "R10 stalled request held", 256'(mem_addr), 256'(prev_addr));
            prev_stall = mem_req && !mem_rdy;
            prev_addr  = mem_addr;
            if (mem_req && mem_rdy) begin
                if (exp_addr.size() == 0)
                    check(0, "R2 read after end of list", 256'(mem_addr), 0);
                else
                    check(int'(mem_addr) == exp_addr[0], exp_atag[0], 256'(mem_addr), 256'(exp_addr[0]));
                if (exp_addr.size() > 0) begin
                    void'(exp_addr.pop_front());
                    void'(exp_atag.pop_front());
                end
            end
            if (rnd_start) begin
                start_cnt++;
                check(!prev_start && !rnd_msg_valid, "R11 start pulse alone", 256'(rnd_msg_valid), 0);
                if (exp_init.size() == 0)
                    check(0, "R11 unexpected start", rnd_init, 0);
                else begin
                    check(rnd_init == exp_init[0], exp_itag[0], rnd_init, exp_init[0]);
                    check(rnd_tag == exp_idx[0], "R3 tag word", 256'(rnd_tag), 256'(exp_idx[0]));
                    void'(exp_init.pop_front());
                    void'(exp_itag.pop_front());
                    void'(exp_idx.pop_front());
                end
            end
            prev_start = rnd_start;
            if (rnd_msg_valid) begin
                if (exp_msg.size() == 0)
                    check(0, "R4 unexpected message word", 256'(rnd_msg), 0);
                else begin
                    check(rnd_msg == exp_msg[0], "R4 message word order", 256'(rnd_msg), 256'(exp_msg[0]));
                    void'(exp_msg.pop_front());
                end
            end
            if (done) done_cnt++;
        end else begin
            prev_stall = 0;
            prev_start = 0;
        end
    end

    task automatic add_job(inout int dp, input logic [15:0] fresh, input int cnt, input logic [31:0] idx,
                           input int srcw, input int digw, input bit corrupt);
        logic [255:0]      ch;
        logic [15:0][31:0] m;
        mem[dp]   = {fresh, 16'(cnt)};
        mem[dp+1] = idx;
        mem[dp+2] = 32'(srcw * 4);
        mem[dp+3] = 32'(digw * 4);
        exp_addr.push_back(dp);   exp_atag.push_back(dp == BASE ? "R1 first header at base" : "R2 header");
        exp_addr.push_back(dp+1); exp_atag.push_back("R3 index word");
        exp_addr.push_back(dp+2); exp_atag.push_back("R3 source word");
        exp_addr.push_back(dp+3); exp_atag.push_back("R3 digest word");
        dp += 4;
        ch = IV;
        for (int b = 0; b < cnt; b++) begin
            if (fresh != 0) ch = IV;
            exp_init.push_back(ch);
            exp_itag.push_back((b > 0 && fresh == 0) ? "R7 chained start state" : "R6 initial start state");
            exp_idx.push_back(idx);
            exp_starts++;
            for (int w = 0; w < 16; w++) begin
                int a;
                a = srcw + 16*b + w;
                mem[a] = (32'(a) * 32'h9e3779b1) ^ 32'h5a5a0f0f;
                m[w] = mem[a];
                exp_addr.push_back(a);
                exp_atag.push_back((b > 0 && w == 0) ? "R5 next block resumes source" : "R4 message read");
                exp_msg.push_back(mem[a]);
            end
            ch = fold(ch, mix(ch, m));
        end
        for (int k = 0; k < 8; k++) mem[digw + k] = ch[32*k +: 32];
        if (corrupt) mem[digw + 5] = mem[digw + 5] ^ 32'h0000_0100;
        for (int j = 0; j < 8; j++) begin
            exp_addr.push_back(digw + 7 - j);
            exp_atag.push_back("R8 digest read downward");
        end
    endtask

    task automatic run(input int mode);
        int dp;
        int n;
        rst_n = 1'b0;
        exp_addr.delete(); exp_atag.delete(); exp_init.delete();
        exp_itag.delete(); exp_idx.delete(); exp_msg.delete();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        exp_starts = 0; done_cnt = 0; start_cnt = 0;
        dp = BASE;
        if (mode != 2) begin
            add_job(dp, 16'h0000, 2, 32'h0000_0011, 256, 512, 1'b0);
            add_job(dp, 16'h0100, 2, 32'h0000_0022, 384, 544, mode == 1);
            add_job(dp, 16'h0000, 1, 32'h0000_0033, 448, 560, 1'b0);
        end
        mem[dp] = 32'hABCD_0000;  // zero count ends the list whatever the upper field holds
        exp_addr.push_back(dp);
        exp_atag.push_back(mode == 2 ? "R1 first header at base" : "R2 end marker read");
        rdy_mode = (mode == 0) ? 1 : 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!done && !mismatch && !rnd_start && !rnd_msg_valid, "R1 outputs idle in reset",
              256'({done, mismatch, rnd_start, rnd_msg_valid}), 0);
        rst_n = 1'b1;
        n = 0;
        while (!done && n < WDOG) begin
            @(negedge clk);
            n++;
        end
        if (n >= WDOG) check(0, "watchdog expired", 256'(n), 256'(WDOG));
        repeat (8) @(negedge clk);
        check(exp_addr.size() == 0, "R8 all planned reads seen", 256'(exp_addr.size()), 0);
        check(exp_msg.size() == 0, "R4 all message words seen", 256'(exp_msg.size()), 0);
        check(start_cnt == exp_starts, "R11 one start per block", 256'(start_cnt), 256'(exp_starts));
        check(done_cnt == 1, "R2 single done pulse", 256'(done_cnt), 1);
        check(!mem_req, "R2 no request after end", 256'(mem_req), 0);
        if (mode == 1)
            check(mismatch == 1'b1, "R9 corrupted digest flagged and held", 256'(mismatch), 1);
        else
            check(mismatch == 1'b0, "R8 matching digests pass", 256'(mismatch), 0);
    endtask

    initial begin
        run(0);
        run(1);
        run(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule